// File: doc/BRIEF.md
# Banked Parallel I/O Expander

This block lets a narrow host port control a wide set of target pins. The target pins are grouped into banks of eight. The host picks one bank with a 3-bit bank select and a 2-bit command, qualifies the access with an active-high chip select, and moves a whole bank at once over an 8-bit data path. It can write a bank's output value, set the bank's direction, or read the bank's pins.

Every bank is reached directly through the select inputs. No other bank has to be shifted or clocked to reach it. Direction is set per bank: one enable bit drives all eight pins of that bank. Pin inputs pass through a two-stage synchroniser before the host sees them.

The host data path is split into an input byte, an output byte and an output-enable. The output-enable tells the pad when it may drive the shared bus. Level translation and pad keepers are left to the board.

Top module: `bank_io_expander`

## Requirements
- R1: While reset is asserted, and after reset, every pin_out bit is 0 and every pin_oe bit is 0.
- R2: When cs=1, strobe=1 and cmd=2'b00, the byte on host_din is stored as the output value of bank bank_sel. The bank's pins pin_out[8*bank_sel +: 8] show that byte after the next rising clock edge.
- R3: When cs=1, strobe=1 and cmd=2'b01, host_din[0] becomes the direction of bank bank_sel. After the next rising edge, all eight bits pin_oe[8*bank_sel +: 8] equal that bit (1 = drive).
- R4: A write changes only the selected bank. The pin_out and pin_oe bits of every other bank keep their values.
- R5: While cs=0, strobe and cmd have no effect, and no pin_out or pin_oe bit changes.
- R6: While strobe=0, no pin_out or pin_oe bit changes, whatever the command.
- R7: With cs=1 and cmd=2'b10, host_dout_en is 1 and host_dout shows the synchronised pins of bank bank_sel. A change on pin_in reaches host_dout after two rising clock edges. A read changes no bank register.
- R8: Whenever cs=0 or cmd is not 2'b10, host_dout_en is 0 and host_dout is 8'h00.
- R9: A bank keeps its output value while its direction bit is 0. When the bank is switched to drive, pin_out still shows the last value written.
- R10: cmd=2'b11 is a no-op, even when it is strobed with cs=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs | input | 1 | Chip select, active high |
| strobe | input | 1 | Transfer strobe; a write happens on a clock edge where it is high |
| cmd | input | 2 | 00 write data, 01 write direction, 10 read pins, 11 no-op |
| bank_sel | input | 3 | Bank index |
| host_din | input | 8 | Write data from the host |
| host_dout | output | 8 | Read data to the host |
| host_dout_en | output | 1 | Drive enable for the host bus pad |
| pin_in | input | 64 | Target pin input values, bank b at bits 8b+7..8b |
| pin_out | output | 64 | Target pin output values |
| pin_oe | output | 64 | Target pin output enables, uniform within each bank |

## Verification
A wrong bank register shows at the ports one clock after the faulty write. The wrong value sits on pin_out or pin_oe of the affected bank. If the write went to the wrong bank, the error shows on a bank that should have stayed still. A fault in the bus direction logic shows on host_dout_en at once, in the same cycle as the command. A fault in the synchroniser shows as a read that arrives one edge too early or too late. That is why the read value is sampled both after one edge and after two.

// File: rtl/bx_pkg.sv
package bx_pkg;
  typedef enum logic [1:0] {
    CMD_WR_DATA = 2'b00,
    CMD_WR_DIR  = 2'b01,
    CMD_RD_PINS = 2'b10,
    CMD_NOP     = 2'b11
  } bx_cmd_e;
endpackage

// File: rtl/bx_host_decode.sv
module bx_host_decode
  import bx_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  localparam int SEL_W = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs,
  input  logic                 strobe,
  input  logic [1:0]           cmd,
  input  logic [SEL_W-1:0]     bank_sel,
  output logic [NUM_BANKS-1:0] wr_data_en,
  output logic [NUM_BANKS-1:0] wr_dir_en,
  output logic                 rd_en
);
  bx_cmd_e op;
  logic    wr_go;

  always_comb begin
    op         = bx_cmd_e'(cmd);
    wr_go      = cs && strobe;
    wr_data_en = '0;
    wr_dir_en  = '0;
    rd_en      = cs && (op == CMD_RD_PINS);
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (wr_go && (bank_sel == SEL_W'(b))) begin
        wr_data_en[b] = (op == CMD_WR_DATA);
        wr_dir_en[b]  = (op == CMD_WR_DIR);
      end
    end
  end

  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_data_en, wr_dir_en})); // R4
  AST_READ_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (wr_data_en == '0) && (wr_dir_en == '0)); // R7
  AST_DESELECT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs || !strobe) |-> (wr_data_en == '0) && (wr_dir_en == '0)); // R5
endmodule

// File: rtl/bx_bank_regs.sv
module bx_bank_regs #(
  parameter int NUM_BANKS = 8,
  parameter int BANK_W    = 8,
  localparam int TOT_W    = NUM_BANKS * BANK_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_BANKS-1:0] wr_data_en,
  input  logic [NUM_BANKS-1:0] wr_dir_en,
  input  logic [BANK_W-1:0]    din,
  output logic [TOT_W-1:0]     out_q,
  output logic [NUM_BANKS-1:0] oe_q
);
  logic [TOT_W-1:0]     out_d;
  logic [NUM_BANKS-1:0] oe_d;

  always_comb begin
    out_d = out_q;
    oe_d  = oe_q;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (wr_data_en[b]) out_d[b*BANK_W +: BANK_W] = din;
      if (wr_dir_en[b])  oe_d[b] = din[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      oe_q  <= '0;
    end else begin
      out_q <= out_d;
      oe_q  <= oe_d;
    end
  end

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_chk
    AST_DATA_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      wr_data_en[g] |=> out_q[g*BANK_W +: BANK_W] == $past(din)); // R2
    AST_DIR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      wr_dir_en[g] |=> oe_q[g] == $past(din[0])); // R3
    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_data_en[g] || wr_dir_en[g]) |=>
        $stable(out_q[g*BANK_W +: BANK_W]) && $stable(oe_q[g])); // R4
    AST_DATA_KEEP_ON_DIR: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_dir_en[g] && !wr_data_en[g]) |=> $stable(out_q[g*BANK_W +: BANK_W])); // R9
  end
endmodule

// File: rtl/bx_in_sync.sv
module bx_in_sync #(
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage1_d;
  logic [WIDTH-1:0] stage2_d;

  always_comb begin
    stage1_d = d;
    stage2_d = stage1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      q        <= '0;
    end else begin
      stage1_q <= stage1_d;
      q        <= stage2_d;
    end
  end
endmodule

// File: rtl/bank_io_expander.sv
module bank_io_expander
  import bx_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int BANK_W    = 8,
  localparam int SEL_W    = $clog2(NUM_BANKS),
  localparam int TOT_W    = NUM_BANKS * BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              strobe,
  input  logic [1:0]        cmd,
  input  logic [SEL_W-1:0]  bank_sel,
  input  logic [BANK_W-1:0] host_din,
  output logic [BANK_W-1:0] host_dout,
  output logic              host_dout_en,
  input  logic [TOT_W-1:0]  pin_in,
  output logic [TOT_W-1:0]  pin_out,
  output logic [TOT_W-1:0]  pin_oe
);
  logic                 rst_meta_q;
  logic                 rst_sync_q;
  logic [NUM_BANKS-1:0] wr_data_en;
  logic [NUM_BANKS-1:0] wr_dir_en;
  logic                 rd_en;
  logic [NUM_BANKS-1:0] bank_oe;
  logic [TOT_W-1:0]     pin_sync;

  // assert asynchronously, release after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  bx_host_decode #(.NUM_BANKS(NUM_BANKS)) u_dec (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .cs         (cs),
    .strobe     (strobe),
    .cmd        (cmd),
    .bank_sel   (bank_sel),
    .wr_data_en (wr_data_en),
    .wr_dir_en  (wr_dir_en),
    .rd_en      (rd_en)
  );

  bx_bank_regs #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .wr_data_en (wr_data_en),
    .wr_dir_en  (wr_dir_en),
    .din        (host_din),
    .out_q      (pin_out),
    .oe_q       (bank_oe)
  );

  bx_in_sync #(.WIDTH(TOT_W)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .d     (pin_in),
    .q     (pin_sync)
  );

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_oe
    assign pin_oe[g*BANK_W +: BANK_W] = {BANK_W{bank_oe[g]}};
  end

  always_comb begin
    host_dout_en = rd_en;
    host_dout    = rd_en ? pin_sync[bank_sel*BANK_W +: BANK_W] : '0;
  end

  AST_DESELECT_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !cs |=> $stable(pin_out) && $stable(pin_oe)); // R5
  AST_NO_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !strobe |=> $stable(pin_out) && $stable(pin_oe)); // R6
  AST_BUS_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_sync_q)
    host_dout_en |-> cs && (cmd == CMD_RD_PINS)); // R8
  AST_NOP_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (cmd == CMD_NOP) |=> $stable(pin_out) && $stable(pin_oe)); // R10
endmodule

// File: tb/tb_bank_io_expander.sv
`timescale 1ns/1ps
module tb_bank_io_expander;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cs;
  logic        strobe;
  logic [1:0]  cmd;
  logic [2:0]  bank_sel;
  logic [7:0]  host_din;
  logic [7:0]  host_dout;
  logic        host_dout_en;
  logic [63:0] pin_in;
  logic [63:0] pin_out;
  logic [63:0] pin_oe;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [7:0] m_out [8];
  logic       m_oe  [8];

  always #2.5 clk = ~clk;

  bank_io_expander dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .strobe(strobe), .cmd(cmd),
    .bank_sel(bank_sel), .host_din(host_din), .host_dout(host_dout),
    .host_dout_en(host_dout_en), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_model(string tag);
    logic [63:0] eo, ee;
    for (int b = 0; b < 8; b++) begin
      eo[b*8 +: 8] = m_out[b];
      ee[b*8 +: 8] = {8{m_oe[b]}};
    end
    chk({tag, " pin_out all banks"}, pin_out, eo);
    chk({tag, " pin_oe all banks"}, pin_oe, ee);
  endtask

  // fields: req[27:24] cs[23] stb[22] cmd[21:20] sel[19:17] din[16:9] exp_out[8:1] exp_oe[0]
  localparam logic [27:0] VEC [12] = '{
    {4'd2,  1'b1, 1'b1, 2'b00, 3'd0, 8'hA5, 8'hA5, 1'b0}, // R2
    {4'd2,  1'b1, 1'b1, 2'b00, 3'd7, 8'h3C, 8'h3C, 1'b0}, // R2
    {4'd3,  1'b1, 1'b1, 2'b01, 3'd0, 8'h01, 8'hA5, 1'b1}, // R3
    {4'd5,  1'b0, 1'b1, 2'b00, 3'd0, 8'hFF, 8'hA5, 1'b1}, // R5
    {4'd6,  1'b1, 1'b0, 2'b00, 3'd0, 8'hFF, 8'hA5, 1'b1}, // R6
    {4'd10, 1'b1, 1'b1, 2'b11, 3'd0, 8'h00, 8'hA5, 1'b1}, // R10
    {4'd3,  1'b1, 1'b1, 2'b01, 3'd0, 8'hFE, 8'hA5, 1'b0}, // R3
    {4'd9,  1'b1, 1'b1, 2'b00, 3'd3, 8'h81, 8'h81, 1'b0}, // R9
    {4'd9,  1'b1, 1'b1, 2'b01, 3'd3, 8'h01, 8'h81, 1'b1}, // R9
    {4'd7,  1'b1, 1'b1, 2'b10, 3'd7, 8'h00, 8'h3C, 1'b0}, // R7
    {4'd5,  1'b0, 1'b1, 2'b01, 3'd7, 8'h01, 8'h3C, 1'b0}, // R5
    {4'd4,  1'b1, 1'b1, 2'b00, 3'd7, 8'hFF, 8'hFF, 1'b0}  // R4
  };

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cs = 1'b0; strobe = 1'b0; cmd = 2'b00;
    bank_sel = 3'd0; host_din = 8'h00; pin_in = '0;
    for (int b = 0; b < 8; b++) begin m_out[b] = 8'h00; m_oe[b] = 1'b0; end
    repeat (3) @(negedge clk);
    chk("R1 pin_out in reset", pin_out, 64'h0);
    chk("R1 pin_oe in reset", pin_oe, 64'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 pin_out after reset", pin_out, 64'h0);
    chk("R1 pin_oe after reset", pin_oe, 64'h0);

    for (int i = 0; i < 12; i++) begin
      logic [27:0] v;
      v = VEC[i];
      cs = v[23]; strobe = v[22]; cmd = v[21:20];
      bank_sel = v[19:17]; host_din = v[16:9];
      if (v[23] && v[22] && v[21:20] == 2'b00) m_out[v[19:17]] = v[16:9];
      if (v[23] && v[22] && v[21:20] == 2'b01) m_oe[v[19:17]] = v[9];
      @(negedge clk);
      chk($sformatf("R%0d vec %0d bank out", v[27:24], i),
          {56'h0, pin_out[v[19:17]*8 +: 8]}, {56'h0, v[8:1]});
      chk($sformatf("R%0d vec %0d bank oe", v[27:24], i),
          {56'h0, pin_oe[v[19:17]*8 +: 8]}, {56'h0, {8{v[0]}}});
      chk_model($sformatf("R4 vec %0d", i));
    end
    cs = 1'b0; strobe = 1'b0;

    // R8: bus quiet when deselected or not reading
    cmd = 2'b10; cs = 1'b0; #1;
    chk("R8 en cs low", {63'h0, host_dout_en}, 64'h0);
    chk("R8 dout cs low", {56'h0, host_dout}, 64'h0);
    cmd = 2'b00; cs = 1'b1; #1;
    chk("R8 en write cmd", {63'h0, host_dout_en}, 64'h0);
    cmd = 2'b11; #1;
    chk("R8 en nop cmd", {63'h0, host_dout_en}, 64'h0);
    cs = 1'b0;
    @(negedge clk);

    // R7: read with two-edge latency
    pin_in = 64'h0011_2233_4455_6677;
    cs = 1'b1; cmd = 2'b10; bank_sel = 3'd5; strobe = 1'b0;
    @(negedge clk);
    chk("R7 not yet after one edge", {56'h0, host_dout}, 64'h0);
    @(negedge clk);
    chk("R7 en during read", {63'h0, host_dout_en}, 64'h1);
    chk("R7 bank5 read", {56'h0, host_dout}, 64'h22);
    bank_sel = 3'd0; #1;
    chk("R7 bank0 read", {56'h0, host_dout}, 64'h77);
    strobe = 1'b1;
    @(negedge clk);
    chk_model("R7 read strobe no write");
    strobe = 1'b0; cs = 1'b0; cmd = 2'b00;
    @(negedge clk);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule